// File: doc/BRIEF.md
# AHB-to-APB Bus Bridge

This block is a slave on an AHB system bus and the only master on an APB peripheral bus. Each AHB transfer that selects it becomes one APB access. That access is a setup cycle followed by an enable cycle. A one-hot select line picks one of sixteen peripherals, using the upper four bits of the peripheral address.

The two buses run on different timing. AHB write data arrives one cycle after its address, so a write is started on the APB one cycle later than a read. A write therefore takes its address from a register, and a read takes it straight from the bus. The bridge can hold one transfer as pending while an APB write is still in progress. This lets writes stream back to back. When a transfer has to wait, the bridge lowers its registered ready output for that transfer's data phase. Read data passes straight from the APB to the AHB. The response is always OKAY.

Top module: `ahb_apb_bridge`

## Requirements
- R1: While `hresetn` is low, the registered outputs are cleared at once, without waiting for a clock edge. That is `psel` = 0, `penable` = 0, `paddr` = 0, `pwrite` = 0 and `pwdata` = 0, with `hready_out` = 1.
- R2: An AHB transfer is accepted only when `hsel` = 1, `hready` = 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). An IDLE (2'b00) or BUSY (2'b01) cycle, or any cycle with `hsel` = 0, starts no APB access.
- R3: Every accepted transfer produces exactly one APB access, in AHB order. The access is one setup cycle (a select line high, `penable` low) and then exactly one enable cycle (`penable` high).
- R4: `paddr` carries the low PADDR_W bits of the transfer address. Exactly one select line is high during an access: the line whose index is `paddr[PADDR_W-1 -: 4]`.
- R5: Outside an access every select line is low. `penable` is high only in the enable cycle.
- R6: `pwrite` is 1 for a write and 0 for a read. For a write, `pwdata` equals the `hwdata` value given in that write's data phase.
- R7: `hrdata` follows `prdata` in the same cycle. A read's AHB data phase ends in the APB enable cycle of that read.
- R8: The number of wait cycles in a data phase depends on the previous accepted transfer and on the gap g, which is the count of non-accepted address slots since that transfer.
  - A read after a write waits 3 cycles when g = 0, 2 when g = 1 and 1 otherwise.
  - Any other read waits 1 cycle.
  - A write directly after a write (g = 0) waits 1 cycle.
  - Any other write waits 0 cycles.
- R9: `hresp` is always 2'b00 (OKAY).
- R10: `paddr`, `pwrite` and the select lines change only when a new setup cycle starts. They are unchanged from the setup cycle to the enable cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock; every register updates on its rising edge |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select from the AHB decoder |
| hready | input | 1 | System ready; high when the previous data phase ends |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for a write transfer |
| haddr | input | HADDR_W | AHB address |
| hwdata | input | DATA_W | AHB write data |
| hready_out | output | 1 | Registered ready of this slave |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | DATA_W | Read data returned to the AHB |
| paddr | output | PADDR_W | APB address |
| psel | output | 16 (1 << SEL_W) | One-hot peripheral selects |
| penable | output | 1 | APB enable phase |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data; zero outside an enable cycle |

## Verification
The setup cycle follows one clock edge after the edge that accepts a read's address, or after the edge that ends a write's data phase. The enable cycle comes one edge after that. `hrdata` is valid in the same cycle as `prdata`. The ready pattern follows from the wait-count rule of R8 and the registered `hready_out`, so a data phase lasts one cycle plus its waits. The bench drives every input one time unit after a rising edge. It reads the ready, the read data and the APB signals at the falling edge, where each value is the one the next rising edge will use. Waits are counted per transfer and compared with the R8 table, which the bench works out from the order of the transfers it issued.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_READ     = 3'd1,
    S_WWAIT    = 3'd2,
    S_WRITE    = 3'd3,
    S_WRITEP   = 3'd4,
    S_RENABLE  = 3'd5,
    S_WENABLE  = 3'd6,
    S_WENABLEP = 3'd7
  } xfer_state_t;

  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  // an address phase that this slave must act on
  function automatic logic xfer_valid(logic sel, logic rdy, logic [1:0] tr);
    return sel && rdy && (tr == HT_NONSEQ || tr == HT_SEQ);
  endfunction

  // next state of the transfer sequencer
  function automatic xfer_state_t step(xfer_state_t cur, logic vld, logic wr,
                                       logic pend_wr);
    xfer_state_t nxt;
    case (cur)
      S_IDLE, S_RENABLE, S_WENABLE:
        nxt = vld ? (wr ? S_WWAIT : S_READ) : S_IDLE;
      S_READ:   nxt = S_RENABLE;
      S_WWAIT:  nxt = vld ? S_WRITEP : S_WRITE;
      S_WRITE:  nxt = vld ? S_WENABLEP : S_WENABLE;
      S_WRITEP: nxt = S_WENABLEP;
      S_WENABLEP:
        nxt = !pend_wr ? S_READ : (vld ? S_WRITEP : S_WRITE);
      default:  nxt = S_IDLE;
    endcase
    return nxt;
  endfunction

  // states in which the AHB data phase is stretched
  function automatic logic wait_needed(xfer_state_t nxt, logic pend_wr);
    return (nxt == S_READ) || (nxt == S_WRITEP) ||
           (nxt == S_WENABLEP && !pend_wr);
  endfunction

  // states that open a new APB setup cycle
  function automatic logic starts_apb(xfer_state_t nxt);
    return (nxt == S_READ) || (nxt == S_WRITE) || (nxt == S_WRITEP);
  endfunction

  // APB enable cycles
  function automatic logic is_access(xfer_state_t nxt);
    return (nxt == S_RENABLE) || (nxt == S_WENABLE) || (nxt == S_WENABLEP);
  endfunction

  // states in which a read is decoded straight from the bus address
  function automatic logic live_addr(xfer_state_t cur);
    return (cur == S_IDLE) || (cur == S_RENABLE) || (cur == S_WENABLE);
  endfunction

  function automatic logic loads_wdata(xfer_state_t nxt);
    return (nxt == S_WRITE) || (nxt == S_WRITEP);
  endfunction

endpackage

// File: rtl/bridge_capture.sv
module bridge_capture
  import bridge_pkg::*;
#(
  parameter int HADDR_W = 32,
  parameter int PADDR_W = 16
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic               hsel,
  input  logic               hready,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [HADDR_W-1:0] haddr,
  output logic               xfer_ok,
  output logic [PADDR_W-1:0] addr_now,
  output logic [PADDR_W-1:0] addr_held,
  output logic               wr_held
);

  assign xfer_ok  = xfer_valid(hsel, hready, htrans);
  assign addr_now = haddr[PADDR_W-1:0];

  // address-phase information kept for the data phase
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      addr_held <= '0;
      wr_held   <= 1'b0;
    end else if (xfer_ok) begin
      addr_held <= addr_now;
      wr_held   <= hwrite;
    end
  end

  generate
    if (HADDR_W > PADDR_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^haddr[HADDR_W-1:PADDR_W];
    end
  endgenerate

endmodule

// File: rtl/bridge_seq_fsm.sv
module bridge_seq_fsm
  import bridge_pkg::*;
(
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        xfer_ok,
  input  logic        hwrite,
  input  logic        wr_held,
  output xfer_state_t state_q,
  output xfer_state_t state_d,
  output logic        hready_q
);

  // direction of the transfer that will be pending after this edge
  logic pend_wr_d;

  assign pend_wr_d = xfer_ok ? hwrite : wr_held;
  assign state_d   = step(state_q, xfer_ok, hwrite, wr_held);

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      state_q  <= S_IDLE;
      hready_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      hready_q <= !wait_needed(state_d, pend_wr_d);
    end
  end

endmodule

// File: rtl/bridge_apb_out.sv
module bridge_apb_out
  import bridge_pkg::*;
#(
  parameter int PADDR_W = 16,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4
) (
  input  logic                    hclk,
  input  logic                    hresetn,
  input  xfer_state_t             state_q,
  input  xfer_state_t             state_d,
  input  logic [PADDR_W-1:0]      addr_now,
  input  logic [PADDR_W-1:0]      addr_held,
  input  logic [DATA_W-1:0]       hwdata,
  output logic [PADDR_W-1:0]      paddr,
  output logic [(1<<SEL_W)-1:0]   psel,
  output logic                    penable,
  output logic                    pwrite,
  output logic [DATA_W-1:0]       pwdata
);

  localparam int NUM_SEL = 1 << SEL_W;

  logic [PADDR_W-1:0] addr_pick;
  logic [SEL_W-1:0]   sel_field;
  logic [NUM_SEL-1:0] sel_dec;
  logic               apb_go;

  assign addr_pick = live_addr(state_q) ? addr_now : addr_held;
  assign sel_field = addr_pick[PADDR_W-1 -: SEL_W];
  assign apb_go    = starts_apb(state_d);

  generate
    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_dec
      assign sel_dec[gi] = (sel_field == SEL_W'(gi));
    end
  endgenerate

  // address, direction and selects move only at a setup cycle
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      psel   <= '0;
    end else if (apb_go) begin
      paddr  <= addr_pick;
      pwrite <= (state_d != S_READ);
      psel   <= sel_dec;
    end else if (!is_access(state_d)) begin
      psel   <= '0;
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) penable <= 1'b0;
    else          penable <= is_access(state_d);
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)                  pwdata <= '0;
    else if (loads_wdata(state_d)) pwdata <= hwdata;
  end

endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
  import bridge_pkg::*;
#(
  parameter int HADDR_W = 32,
  parameter int PADDR_W = 16,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4
) (
  input  logic                  hclk,
  input  logic                  hresetn,
  input  logic                  hsel,
  input  logic                  hready,
  input  logic [1:0]            htrans,
  input  logic                  hwrite,
  input  logic [HADDR_W-1:0]    haddr,
  input  logic [DATA_W-1:0]     hwdata,
  output logic                  hready_out,
  output logic [1:0]            hresp,
  output logic [DATA_W-1:0]     hrdata,
  output logic [PADDR_W-1:0]    paddr,
  output logic [(1<<SEL_W)-1:0] psel,
  output logic                  penable,
  output logic                  pwrite,
  output logic [DATA_W-1:0]     pwdata,
  input  logic [DATA_W-1:0]     prdata
);

  logic               xfer_ok;
  logic [PADDR_W-1:0] addr_now;
  logic [PADDR_W-1:0] addr_held;
  logic               wr_held;
  xfer_state_t        fsm_state;
  xfer_state_t        fsm_next;

  bridge_capture #(.HADDR_W(HADDR_W), .PADDR_W(PADDR_W)) u_capture (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .hready    (hready),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .haddr     (haddr),
    .xfer_ok   (xfer_ok),
    .addr_now  (addr_now),
    .addr_held (addr_held),
    .wr_held   (wr_held)
  );

  bridge_seq_fsm u_fsm (
    .hclk     (hclk),
    .hresetn  (hresetn),
    .xfer_ok  (xfer_ok),
    .hwrite   (hwrite),
    .wr_held  (wr_held),
    .state_q  (fsm_state),
    .state_d  (fsm_next),
    .hready_q (hready_out)
  );

  bridge_apb_out #(.PADDR_W(PADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_apb (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .state_q   (fsm_state),
    .state_d   (fsm_next),
    .addr_now  (addr_now),
    .addr_held (addr_held),
    .hwdata    (hwdata),
    .paddr     (paddr),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pwdata    (pwdata)
  );

  // peripherals drive zero outside their enable cycle
  assign hrdata = prdata;
  assign hresp  = 2'b00;

endmodule

// File: rtl/ahb_apb_bridge_chk.sv
module ahb_apb_bridge_chk
  import bridge_pkg::*;
#(
  parameter int PADDR_W = 16,
  parameter int SEL_W   = 4
) (
  input logic                  hclk,
  input logic                  hresetn,
  input logic [PADDR_W-1:0]    paddr,
  input logic [(1<<SEL_W)-1:0] psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic                  hready_out,
  input xfer_state_t           state
);

  // R5
  enable_has_sel_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> (psel != '0));

  // R3
  enable_after_setup_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> $past((psel != '0) && !penable));

  // R3
  setup_then_enable_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    ((psel != '0) && !penable) |=> penable);

  // R10
  stable_in_enable_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> ($stable(paddr) && $stable(psel) && $stable(pwrite)));

  // R4
  sel_onehot_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(psel));

  // R4
  sel_matches_addr_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (psel != '0) |-> psel[paddr[PADDR_W-1 -: SEL_W]]);

  // R8
  read_stall_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    ((state == S_READ) || (state == S_WRITEP)) |-> !hready_out);

  // R8
  write_no_stall_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    ((state == S_WWAIT) || (state == S_RENABLE)) |-> hready_out);

endmodule

bind ahb_apb_bridge ahb_apb_bridge_chk #(.PADDR_W(PADDR_W), .SEL_W(SEL_W)) u_chk (
  .hclk       (hclk),
  .hresetn    (hresetn),
  .paddr      (paddr),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .hready_out (hready_out),
  .state      (fsm_state)
);

// File: tb/test_ahb_apb_bridge.sv
module test_ahb_apb_bridge;

  logic        hclk = 1'b0;
  logic        hresetn;
  logic        hsel;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [31:0] haddr;
  logic [31:0] hwdata;
  logic        hready_out;
  logic [1:0]  hresp;
  logic [31:0] hrdata;
  logic [15:0] paddr;
  logic [15:0] psel;
  logic        penable;
  logic        pwrite;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        hready;

  int n_chk = 0;
  int n_err = 0;

  always #5 hclk = ~hclk;

  assign hready = hready_out;

  ahb_apb_bridge i_ahb_apb_bridge (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .hready(hready),
    .htrans(htrans), .hwrite(hwrite), .haddr(haddr), .hwdata(hwdata),
    .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata)
  );

  function automatic logic [31:0] wdata_of(logic [15:0] a);
    return {~a, a ^ 16'h3C3C};
  endfunction

  function automatic logic [31:0] rd_of(logic [15:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

  // APB peripheral model: data only in a read enable cycle
  assign prdata = ((psel != 16'h0) && penable && !pwrite) ? rd_of(paddr) : 32'h0;

  // APB monitor
  logic [15:0] lg_addr [64];
  logic        lg_wr   [64];
  logic [31:0] lg_data [64];
  logic [15:0] lg_sel  [64];
  logic        lg_ok   [64];
  int          ln = 0;
  logic        s_valid = 1'b0;
  logic [15:0] s_addr, s_sel;
  logic        s_wr;
  logic        hresp_bad = 1'b0;

  always @(negedge hclk) begin
    if (hresp != 2'b00) hresp_bad <= 1'b1;
    if (!hresetn) begin
      s_valid <= 1'b0;
    end else if ((psel != 16'h0) && !penable) begin
      s_valid <= 1'b1; s_addr <= paddr; s_sel <= psel; s_wr <= pwrite;
    end else if (penable) begin
      lg_addr[ln % 64] <= paddr;
      lg_wr[ln % 64]   <= pwrite;
      lg_data[ln % 64] <= pwdata;
      lg_sel[ln % 64]  <= psel;
      lg_ok[ln % 64]   <= s_valid && (s_addr == paddr) && (s_sel == psel) &&
                          (s_wr == pwrite);
      ln <= ln + 1;
      s_valid <= 1'b0;
    end else begin
      s_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // transfer list for one sequence
  logic [15:0] t_addr [16];
  logic        t_wr   [16];
  logic        t_sel  [16];
  logic        t_seqt [16];
  int          t_gap  [16];
  int          t_wait [16];
  logic [31:0] t_rd   [16];
  int          n_x;
  logic        busy_gap;

  task automatic drive_addr(input int a, input int gl);
    if (a < n_x && gl == 0) begin
      hsel   = t_sel[a];
      htrans = t_seqt[a] ? 2'b11 : 2'b10;
      hwrite = t_wr[a];
      haddr  = {16'hA5C3 ^ 16'(a), t_addr[a]};
    end else begin
      hsel   = 1'b1;
      htrans = busy_gap ? 2'b01 : 2'b00;
      hwrite = ~hwrite;
      haddr  = 32'hFFFF_F0F0;
    end
  endtask

  task automatic run_seq();
    int a = 0;
    int d = -1;
    int gl = t_gap[0];
    for (int i = 0; i < 16; i++) begin t_wait[i] = 0; t_rd[i] = 32'h0; end
    drive_addr(a, gl);
    for (int it = 0; it < 400; it++) begin
      bit hr;
      int nd = -1;
      @(negedge hclk);
      hr = hready_out;
      if (d >= 0 && !hr) t_wait[d]++;
      if (hr) begin
        if (d >= 0 && !t_wr[d]) t_rd[d] = hrdata;
        if (a < n_x && gl == 0) begin
          nd = t_sel[a] ? a : -1;
          a++;
          gl = (a < n_x) ? t_gap[a] : 0;
        end else if (gl > 0) begin
          gl--;
        end
      end
      @(posedge hclk); #1;
      if (hr) begin
        d = nd;
        hwdata = (d >= 0 && t_wr[d]) ? wdata_of(t_addr[d]) : 32'h0;
        drive_addr(a, gl);
      end
      if (a >= n_x && d == -1) break;
    end
    repeat (5) @(posedge hclk);
    #1;
  endtask

  task automatic run_and_check();
    int base = ln;
    int j = 0;
    int own = 0;
    int eg = 0;
    bit have_prev = 0;
    bit prev_w = 0;
    run_seq();
    for (int i = 0; i < n_x; i++) begin
      int e;
      int k;
      if (!t_sel[i]) begin eg += t_gap[i] + 1; continue; end
      eg += t_gap[i];
      if (t_wr[i]) e = (have_prev && prev_w && eg == 0) ? 1 : 0;
      else if (have_prev && prev_w) e = (eg == 0) ? 3 : ((eg == 1) ? 2 : 1);
      else e = 1;
      // R8 wait cycles of this data phase
      chk(t_wait[i] == e, "R8 wait count", 32'(t_wait[i]), 32'(e));
      k = (base + j) % 64;
      // R3 R10 setup/enable pairing with stable controls
      chk(lg_ok[k], "R3 R10 setup then enable", 32'(lg_ok[k]), 32'h1);
      // R4 address and select line
      chk(lg_addr[k] == t_addr[i], "R4 paddr", 32'(lg_addr[k]), 32'(t_addr[i]));
      chk(lg_sel[k] == (16'h1 << t_addr[i][15:12]), "R4 psel",
          32'(lg_sel[k]), 32'(16'h1 << t_addr[i][15:12]));
      // R6 direction
      chk(lg_wr[k] == t_wr[i], "R6 pwrite", 32'(lg_wr[k]), 32'(t_wr[i]));
      if (t_wr[i])
        chk(lg_data[k] == wdata_of(t_addr[i]), "R6 pwdata", lg_data[k],
            wdata_of(t_addr[i]));
      else
        // R7 read data reaches the AHB
        chk(t_rd[i] == rd_of(t_addr[i]), "R7 hrdata", t_rd[i], rd_of(t_addr[i]));
      prev_w = t_wr[i]; have_prev = 1; eg = 0; j++; own++;
    end
    // R2 R3 one access per accepted transfer, none for ignored cycles
    chk(ln - base == own, "R2 R3 access count", 32'(ln - base), 32'(own));
    // R5 bus quiet after the sequence
    chk(psel == 16'h0 && !penable, "R5 idle selects", {psel, 15'h0, penable}, 32'h0);
    // R9 always OKAY
    chk(hresp == 2'b00 && !hresp_bad, "R9 hresp", 32'(hresp), 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge hclk);
    n_err++;
    $display("FAIL watchdog expired (R3 progress)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int sq = 0;
    hresetn = 1'b0;
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; haddr = 32'h0; hwdata = 32'h0;
    busy_gap = 1'b0;
    #12;
    // R1 state held in reset
    chk(psel == 16'h0 && !penable && !pwrite, "R1 reset selects/enable",
        {psel, 14'h0, penable, pwrite}, 32'h0);
    chk(paddr == 16'h0 && pwdata == 32'h0, "R1 reset paddr/pwdata", {paddr, 16'h0} | pwdata, 32'h0);
    chk(hready_out == 1'b1, "R1 reset ready", 32'(hready_out), 32'h1);
    #10 hresetn = 1'b1;
    @(posedge hclk); #1;

    // all read/write orders of three transfers with gaps of 0..2
    for (int p = 0; p < 8; p++)
      for (int g1 = 0; g1 < 3; g1++)
        for (int g2 = 0; g2 < 3; g2++) begin
          n_x = 3;
          busy_gap = sq[0];
          for (int i = 0; i < 3; i++) begin
            t_wr[i]   = ((p >> i) & 1) != 0;
            t_sel[i]  = 1'b1;
            t_seqt[i] = (i == 2);
            t_addr[i] = {4'((sq * 3 + i) % 16), 12'((sq * 37 + i * 101) & 12'hFFF)};
          end
          t_gap[0] = 0; t_gap[1] = g1; t_gap[2] = g2;
          run_and_check();
          sq++;
        end

    // R2 transfers for another slave are ignored
    n_x = 4; busy_gap = 1'b0;
    t_wr[0] = 1; t_wr[1] = 1; t_wr[2] = 0; t_wr[3] = 1;
    t_sel[0] = 1; t_sel[1] = 0; t_sel[2] = 1; t_sel[3] = 1;
    for (int i = 0; i < 4; i++) begin
      t_seqt[i] = 1'b0; t_gap[i] = 0; t_addr[i] = {4'(i * 5 + 2), 12'(i * 291)};
    end
    run_and_check();

    // long back-to-back stream over all sixteen selects
    n_x = 16; busy_gap = 1'b1;
    for (int i = 0; i < 16; i++) begin
      t_wr[i] = (i % 3) != 2; t_sel[i] = 1'b1; t_seqt[i] = (i % 2) == 1;
      t_gap[i] = 0; t_addr[i] = {4'(15 - i), 12'(i * 257 + 17)};
    end
    run_and_check();

    // R1 asynchronous reset in the middle of a write
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0000_7ABC;
    @(posedge hclk); #1;
    htrans = 2'b00; hwdata = wdata_of(16'h7ABC);
    @(posedge hclk); #3;
    chk(psel == 16'h0080 && paddr == 16'h7ABC, "R4 setup before reset",
        {psel, paddr}, {16'h0080, 16'h7ABC});
    hresetn = 1'b0;
    #1;
    chk(psel == 16'h0 && !penable && !pwrite && paddr == 16'h0,
        "R1 async clear of APB controls", {psel, paddr}, 32'h0);
    chk(pwdata == 32'h0 && hready_out, "R1 async clear of data/ready",
        pwdata, 32'h0);
    @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);
    chk(psel == 16'h0 && !penable, "R5 quiet after reset", 32'(psel), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule